// File: doc/BRIEF.md
# Two-Pattern Scan Chain with Holding Stage

This block is a serial scan chain for delay testing. Each scan flip-flop feeds a holding stage, and the holding stage drives the logic under test. Because the holding stage sits between the chain and the logic, the chain can take a complete new vector while the logic still sees the previous one. A test can therefore launch any second vector after any first vector. The second vector does not have to be a shifted or captured version of the first.

A test runs in six steps:

1. With the holding stage frozen, shift the first vector in through the serial input.
2. Open the holding stage for one clock so that the logic sees the first vector.
3. Freeze the holding stage and shift in the second vector. During this time the first vector stays applied and the logic settles.
4. Open the holding stage for one clock. This launches the second vector.
5. On the next clock, with the test-control input low, load every flop in parallel from the logic outputs.
6. Shift the captured response out.

The holding stage is a clocked register with a load enable, so that the block can be synthesized. The stage loads when the hold input is low and keeps its value when the hold input is high.

Top module: `esc_chain`

## Requirements
- R1: A clock edge with `rst` high clears all scan flops and all holding stages to zero. As a result, `state_out` reads 0 and `scan_out` reads 0.
- R2: On a clock edge with `test_ctrl` = 1 (shift), flop 0 takes `scan_in` and flop i takes flop i-1. `scan_out` always shows flop WIDTH-1. To load vector V, drive V[WIDTH-1] first and V[0] last. A captured response leaves `scan_out` with bit WIDTH-1 first.
- R3: On a clock edge with `hold` = 1, `state_out` keeps its value, even while the flops shift.
- R4: On a clock edge with `hold` = 0, `state_out` takes the contents the scan flops had before that edge.
- R5: On a clock edge with `test_ctrl` = 0 (capture), all WIDTH flops load `capture_in` in parallel on that single edge.
- R6: For every pair of vectors V1 and V2, `state_out` shows V1 throughout the shifting of V2. `state_out` shows exactly V2 after the release edge, whatever V1 was.
- R7: Capture happens one clock after the edge that launches V2. The response shifted out then equals the response of the logic under test to V2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| test_ctrl | input | 1 | 1 = serial shift, 0 = parallel capture |
| hold | input | 1 | 1 = holding stage keeps its value, 0 = holding stage loads the chain |
| scan_in | input | 1 | Serial scan input into flop 0 |
| capture_in | input | WIDTH | Outputs of the logic under test |
| state_out | output | WIDTH | Holding-stage outputs that drive the logic under test |
| scan_out | output | 1 | Serial output from flop WIDTH-1 |

## Verification
The bench builds the chain with WIDTH = 4. At this width every ordered pair of vectors can be tried: all 256 combinations of V1 and V2. This covers every launch transition on every bit, including pairs with no change and pairs where every bit flips. It also covers the case where V2 cannot be reached from V1 by a one-bit shift. A bench function serves as the logic under test. Each response that is shifted out is compared with that function applied to V2. The bench also checks that `state_out` holds V1 at every step of the V2 shift.

// File: rtl/esc_pkg.sv
package esc_pkg;

    typedef enum logic {
        ESC_CAPTURE = 1'b0,
        ESC_SHIFT   = 1'b1
    } esc_mode_e;

    typedef struct packed {
        logic serial_d;
        logic parallel_d;
    } esc_cell_in_t;

    function automatic logic esc_next(input esc_mode_e mode, input esc_cell_in_t din);
        return (mode == ESC_SHIFT) ? din.serial_d : din.parallel_d;
    endfunction

endpackage

// File: rtl/esc_scan_ff.sv
module esc_scan_ff
    import esc_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  esc_mode_e    mode,
    input  esc_cell_in_t din,
    output logic         q
);

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= esc_next(mode, din);
    end

    // R2 / R5: the flop follows the source that the mode selects
    p_flop_src_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == ESC_SHIFT) |=> q == $past(din.serial_d));
    p_flop_cap_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == ESC_CAPTURE) |=> q == $past(din.parallel_d));

endmodule

// File: rtl/esc_hold_stage.sv
module esc_hold_stage (
    input  logic clk,
    input  logic rst,
    input  logic hold,
    input  logic d,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)        q <= 1'b0;
        else if (!hold) q <= d;
    end

    p_hold_keep_r3: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(q));
    p_hold_load_r4: assert property (@(posedge clk) disable iff (rst)
        !hold |=> q == $past(d));

endmodule

// File: rtl/esc_chain.sv
module esc_chain
    import esc_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             test_ctrl,
    input  logic             hold,
    input  logic             scan_in,
    input  logic [WIDTH-1:0] capture_in,
    output logic [WIDTH-1:0] state_out,
    output logic             scan_out
);

    localparam int LAST = WIDTH - 1;

    esc_mode_e        mode;
    logic [WIDTH-1:0] ff_q;

    assign mode = test_ctrl ? ESC_SHIFT : ESC_CAPTURE;

    for (genvar i = 0; i < WIDTH; i++) begin : g_cell
        esc_cell_in_t din;
        if (i == 0) begin : g_head
            assign din.serial_d = scan_in;
        end else begin : g_body
            assign din.serial_d = ff_q[i-1];
        end
        assign din.parallel_d = capture_in[i];

        esc_scan_ff u_ff (
            .clk  (clk),
            .rst  (rst),
            .mode (mode),
            .din  (din),
            .q    (ff_q[i])
        );

        esc_hold_stage u_hold (
            .clk  (clk),
            .rst  (rst),
            .hold (hold),
            .d    (ff_q[i]),
            .q    (state_out[i])
        );
    end

    assign scan_out = ff_q[LAST];

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (state_out == '0) && (scan_out == 1'b0));
    p_shift_head_r2: assert property (@(posedge clk) disable iff (rst)
        test_ctrl |=> ff_q[0] == $past(scan_in));
    p_capture_all_r5: assert property (@(posedge clk) disable iff (rst)
        !test_ctrl |=> ff_q == $past(capture_in));
    p_frozen_vec_r6: assert property (@(posedge clk) disable iff (rst)
        hold |=> state_out == $past(state_out));

endmodule

// File: tb/esc_chain_test.sv
module esc_chain_test;

    localparam int CLK_PERIOD = 10;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         test_ctrl = 1'b1;
    logic         hold = 1'b1;
    logic         scan_in = 1'b0;
    logic [W-1:0] capture_in;
    logic [W-1:0] state_out;
    logic         scan_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Stand-in for the logic under test
    function automatic logic [W-1:0] lut_fn(input logic [W-1:0] x);
        logic [W-1:0] rot;
        rot = {x[W-2:0], x[W-1]};
        return (rot ^ (x + 4'd3)) ^ 4'b0110;
    endfunction

    always_comb capture_in = lut_fn(state_out);

    esc_chain #(.WIDTH(W)) uut (
        .clk        (clk),
        .rst        (rst),
        .test_ctrl  (test_ctrl),
        .hold       (hold),
        .scan_in    (scan_in),
        .capture_in (capture_in),
        .state_out  (state_out),
        .scan_out   (scan_out)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] got;
        rst = 1'b1;
        tick(); tick();
        check("R1 state_out", state_out, '0);
        check("R1 scan_out", {3'b0, scan_out}, '0);
        rst = 1'b0;

        // R3: hold high keeps zero state while ones stream through; R2 delay of W
        hold = 1'b1; test_ctrl = 1'b1; scan_in = 1'b1;
        for (int k = 0; k < W - 1; k++) begin
            tick();
            check("R2 scan_out latency", {3'b0, scan_out}, '0);
        end
        tick();
        check("R2 scan_out after W shifts", {3'b0, scan_out}, 4'd1);
        check("R3 state frozen", state_out, '0);

        for (int p = 0; p < 256; p++) begin
            logic [W-1:0] v1, v2;
            v1 = p[7:4];
            v2 = p[3:0];
            // shift V1 with hold high
            hold = 1'b1; test_ctrl = 1'b1;
            for (int k = W - 1; k >= 0; k--) begin
                scan_in = v1[k];
                tick();
            end
            // first V2 bit: open holding stage, V1 gets applied
            hold = 1'b0; scan_in = v2[W-1];
            tick();
            check("R4 V1 applied", state_out, v1);
            hold = 1'b1;
            for (int k = W - 2; k >= 0; k--) begin
                scan_in = v2[k];
                tick();
                check("R6 V1 held during V2 shift", state_out, v1);
            end
            // release: launch V2
            hold = 1'b0;
            tick();
            check("R6 V2 applied", state_out, v2);
            // capture one clock later
            hold = 1'b1; test_ctrl = 1'b0;
            tick();
            check("R3 V2 kept at capture", state_out, v2);
            test_ctrl = 1'b1; scan_in = 1'b0;
            got = '0;
            got[W-1] = scan_out;
            for (int k = W - 2; k >= 0; k--) begin
                tick();
                got[k] = scan_out;
            end
            check("R5 R7 response", got, lut_fn(v2));
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule